// File: doc/BRIEF.md
# Load-Store Byte Lane Unit

This unit sits between a 32-bit core and a byte-addressed data memory whose data port is one 32-bit word wide. On the load path it takes the word read from memory and picks out the addressed byte, halfword or word, using the two low address bits. It then widens the selected value to 32 bits, either by copying its sign bit upward or by filling with zeros. On the store path it places the core's byte or halfword on every lane where it could land. It also produces one write enable per byte, so that only the addressed bytes of the memory word change.

Lanes are little endian: byte lane k holds bits 8k+7 down to 8k and answers to address offset k. An access whose address is not a multiple of its size is flagged as misaligned. Such an access produces no write enables and a zero load result. The logic is combinational. A parameter places one register stage on all outputs, and it is enabled by default.

Top module: `lsu_lane_unit`

## Requirements
- R1: Lanes are little endian. A byte access at offset k (addr_lo) selects bits 8k+7:8k of mem_rdata. A halfword access at offset 0 selects bits 15:0, and one at offset 2 selects bits 31:16.
- R2: An unsigned byte or halfword load (ld_signed = 0) fills every bit above the selected value with zero.
- R3: A signed byte load (ld_signed = 1) copies bit 7 of the selected byte into result bits 31:8.
- R4: A signed halfword load copies bit 15 of the selected halfword into result bits 31:16.
- R5: An aligned word load returns mem_rdata unchanged, and ld_signed has no effect on it.
- R6: acc_size encodes 2'b00 as byte, 2'b01 as halfword and 2'b10 as word. The code 2'b11 is reserved and is always reported as misaligned.
- R7: misalign is 1 in three cases: a halfword with addr_lo[0] = 1, a word with addr_lo != 0, or the reserved size. A misaligned access gives ld_data = 0 and wr_be = 4'b0000.
- R8: On the store data path, wr_data holds four copies of st_data[7:0] for a byte, two copies of st_data[15:0] for a halfword, and st_data itself for a word or the reserved size.
- R9: wr_be bit k enables byte lane k. An aligned store drives 4'b0001 shifted left by addr_lo for a byte, 4'b0011 (offset 0) or 4'b1100 (offset 2) for a halfword, and 4'b1111 for a word. When is_store = 0, wr_be is 4'b0000.
- R10: With OUT_REG = 1, every output shows the result for the inputs present at the previous rising clock edge. While rst_n = 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| addr_lo | input | 2 | Byte offset of the access within the word |
| acc_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| ld_signed | input | 1 | 1 selects sign extension for byte and halfword loads |
| is_store | input | 1 | 1 marks a store access |
| mem_rdata | input | 32 | Word read from data memory |
| st_data | input | 32 | Store data from the core, right aligned |
| ld_data | output | 32 | Extended load result |
| wr_data | output | 32 | Lane-replicated store data for memory |
| wr_be | output | 4 | Per-byte write enables |
| misalign | output | 1 | Access is not aligned to its size |

## Verification
The bench targets the lane extremes: offsets 0 and 3 for bytes, and both halves for halfwords. A design that mirrored the lane order would return the byte from the opposite end of the word. Sign extension is tested with values whose top bit is set and values whose top bit is clear. A design that tested the wrong bit, or always sign-extended, would return a wrong upper part of the result. Misaligned halfwords and words and the reserved size code are applied to stores, where a design that forgot to gate the enables would corrupt memory. Finally, the bench steps the inputs between clock edges to show that the output register delays each result by exactly one edge.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } lane_size_e;

    typedef struct packed {
        logic [WORD_W-1:0] ld;
        logic [WORD_W-1:0] wd;
        logic [LANES-1:0]  be;
        logic              mis;
    } lane_out_t;
endpackage

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
    import lsu_lane_pkg::*;
(
    input  logic [OFF_W-1:0] addr_lo,
    input  lane_size_e       size,
    output logic             mis
);
    always_comb begin
        case (size)
            SZ_BYTE: mis = 1'b0;
            SZ_HALF: mis = addr_lo[0];
            SZ_WORD: mis = |addr_lo;
            default: mis = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
    import lsu_lane_pkg::*;
(
    input  logic [WORD_W-1:0] rdata,
    input  logic [OFF_W-1:0]  addr_lo,
    input  lane_size_e        size,
    input  logic              sgn,
    input  logic              mis,
    output logic [WORD_W-1:0] ld
);
    logic [WORD_W-1:0] shifted;

    // Bring the addressed lane down to bit 0 (little endian).
    assign shifted = rdata >> {addr_lo, 3'b000};

    always_comb begin
        if (mis) begin
            ld = '0;
        end else begin
            case (size)
                SZ_BYTE: ld = {{(WORD_W-8){sgn & shifted[7]}}, shifted[7:0]};
                SZ_HALF: ld = {{(WORD_W-16){sgn & shifted[15]}}, shifted[15:0]};
                default: ld = shifted;
            endcase
        end
    end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
    import lsu_lane_pkg::*;
(
    input  logic [WORD_W-1:0] st_data,
    input  logic [OFF_W-1:0]  addr_lo,
    input  lane_size_e        size,
    input  logic              is_store,
    input  logic              mis,
    output logic [WORD_W-1:0] wd,
    output logic [LANES-1:0]  be
);
    always_comb begin
        case (size)
            SZ_BYTE: wd = {LANES{st_data[7:0]}};
            SZ_HALF: wd = {(LANES/2){st_data[15:0]}};
            default: wd = st_data;
        endcase
    end

    // One enable per lane, decoded from the offset and the access size.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic hit;
        always_comb begin
            case (size)
                SZ_BYTE: hit = (addr_lo == OFF_W'(k));
                SZ_HALF: hit = (addr_lo[OFF_W-1:1] == (OFF_W-1)'(k / 2));
                SZ_WORD: hit = 1'b1;
                default: hit = 1'b0;
            endcase
        end
        assign be[k] = is_store & ~mis & hit;
    end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_lane_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr_lo,
    input  logic [1:0]        acc_size,
    input  logic              ld_signed,
    input  logic              is_store,
    input  logic [31:0]       mem_rdata,
    input  logic [31:0]       st_data,
    output logic [31:0]       ld_data,
    output logic [31:0]       wr_data,
    output logic [3:0]        wr_be,
    output logic              misalign
);
    lane_size_e        size;
    logic              mis;
    logic [WORD_W-1:0] ld_w;
    logic [WORD_W-1:0] wd_w;
    logic [LANES-1:0]  be_w;
    lane_out_t         out_d;
    lane_out_t         out_q;

    assign size = lane_size_e'(acc_size);

    lsu_align_chk u_align (
        .addr_lo (addr_lo),
        .size    (size),
        .mis     (mis)
    );

    lsu_load_ext u_load (
        .rdata   (mem_rdata),
        .addr_lo (addr_lo),
        .size    (size),
        .sgn     (ld_signed),
        .mis     (mis),
        .ld      (ld_w)
    );

    lsu_store_lane u_store (
        .st_data  (st_data),
        .addr_lo  (addr_lo),
        .size     (size),
        .is_store (is_store),
        .mis      (mis),
        .wd       (wd_w),
        .be       (be_w)
    );

    always_comb begin
        out_d     = '0;
        out_d.ld  = ld_w;
        out_d.wd  = wd_w;
        out_d.be  = be_w;
        out_d.mis = mis;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign ld_data  = out_q.ld;
    assign wr_data  = out_q.wd;
    assign wr_be    = out_q.be;
    assign misalign = out_q.mis;
endmodule

// File: rtl/lsu_lane_chk.sv
module lsu_lane_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ld_data,
    input logic [31:0] wr_data,
    input logic [3:0]  wr_be,
    input logic        misalign
);
    // R7
    mis_no_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (wr_be == 4'b0000));

    // R7
    mis_zero_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (ld_data == 32'h0));

    // R9
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(wr_be) <= 1) || (wr_be == 4'b0011) ||
        (wr_be == 4'b1100) || (wr_be == 4'b1111));

    // R8
    byte_repl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(wr_be) == 1) |->
            ((wr_data[31:24] == wr_data[7:0]) && (wr_data[23:16] == wr_data[7:0]) &&
             (wr_data[15:8] == wr_data[7:0])));

    // R8
    half_repl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(wr_be) == 2) |-> (wr_data[31:16] == wr_data[15:0]));
endmodule

bind lsu_lane_unit lsu_lane_chk u_lane_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_data  (ld_data),
    .wr_data  (wr_data),
    .wr_be    (wr_be),
    .misalign (misalign)
);

// File: tb/tb_lsu_lane_unit.sv
module tb_lsu_lane_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr_lo = '0;
    logic [1:0]  acc_size = '0;
    logic        ld_signed = 1'b0;
    logic        is_store = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] st_data = '0;
    logic [31:0] ld_data;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic        misalign;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lsu_lane_unit dut (
        .clk(clk), .rst_n(rst_n), .addr_lo(addr_lo), .acc_size(acc_size),
        .ld_signed(ld_signed), .is_store(is_store), .mem_rdata(mem_rdata),
        .st_data(st_data), .ld_data(ld_data), .wr_data(wr_data),
        .wr_be(wr_be), .misalign(misalign)
    );

    localparam logic [31:0] MEMW = 32'h8476_F1A2;
    localparam logic [31:0] STW  = 32'h1234_56C9;
    localparam int NV = 19;
    // {store, size, signed, addr, exp ld, exp wr_data, exp be, exp misalign}
    localparam logic [74:0] VEC [NV] = '{
        {1'b0, 2'b00, 1'b0, 2'd0, 32'h0000_00A2, 32'hC9C9_C9C9, 4'b0000, 1'b0}, // R2 R1
        {1'b0, 2'b00, 1'b1, 2'd0, 32'hFFFF_FFA2, 32'hC9C9_C9C9, 4'b0000, 1'b0}, // R3
        {1'b0, 2'b00, 1'b1, 2'd2, 32'h0000_0076, 32'hC9C9_C9C9, 4'b0000, 1'b0}, // R3 R1
        {1'b0, 2'b00, 1'b0, 2'd3, 32'h0000_0084, 32'hC9C9_C9C9, 4'b0000, 1'b0}, // R2 R1
        {1'b0, 2'b00, 1'b1, 2'd3, 32'hFFFF_FF84, 32'hC9C9_C9C9, 4'b0000, 1'b0}, // R3
        {1'b0, 2'b01, 1'b1, 2'd0, 32'hFFFF_F1A2, 32'h56C9_56C9, 4'b0000, 1'b0}, // R4
        {1'b0, 2'b01, 1'b0, 2'd2, 32'h0000_8476, 32'h56C9_56C9, 4'b0000, 1'b0}, // R2 R1
        {1'b0, 2'b01, 1'b1, 2'd2, 32'hFFFF_8476, 32'h56C9_56C9, 4'b0000, 1'b0}, // R4
        {1'b0, 2'b10, 1'b1, 2'd0, 32'h8476_F1A2, 32'h1234_56C9, 4'b0000, 1'b0}, // R5
        {1'b0, 2'b01, 1'b0, 2'd1, 32'h0000_0000, 32'h56C9_56C9, 4'b0000, 1'b1}, // R7
        {1'b0, 2'b10, 1'b0, 2'd2, 32'h0000_0000, 32'h1234_56C9, 4'b0000, 1'b1}, // R7
        {1'b1, 2'b00, 1'b0, 2'd1, 32'h0000_00F1, 32'hC9C9_C9C9, 4'b0010, 1'b0}, // R9 R8
        {1'b1, 2'b00, 1'b0, 2'd3, 32'h0000_0084, 32'hC9C9_C9C9, 4'b1000, 1'b0}, // R9
        {1'b1, 2'b01, 1'b0, 2'd2, 32'h0000_8476, 32'h56C9_56C9, 4'b1100, 1'b0}, // R9 R8
        {1'b1, 2'b01, 1'b0, 2'd0, 32'h0000_F1A2, 32'h56C9_56C9, 4'b0011, 1'b0}, // R9
        {1'b1, 2'b10, 1'b0, 2'd0, 32'h8476_F1A2, 32'h1234_56C9, 4'b1111, 1'b0}, // R9 R8
        {1'b1, 2'b01, 1'b0, 2'd3, 32'h0000_0000, 32'h56C9_56C9, 4'b0000, 1'b1}, // R7
        {1'b1, 2'b10, 1'b0, 2'd1, 32'h0000_0000, 32'h1234_56C9, 4'b0000, 1'b1}, // R7
        {1'b1, 2'b11, 1'b0, 2'd0, 32'h0000_0000, 32'h1234_56C9, 4'b0000, 1'b1}  // R6
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 3, 6:      return "R2";
            1, 2, 4:      return "R3";
            5, 7:         return "R4";
            8:            return "R5";
            9, 10, 16, 17: return "R7";
            18:           return "R6";
            default:      return "R9";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic st, logic [1:0] sz, logic sg, logic [1:0] a,
                         logic [31:0] rd, logic [31:0] sd);
        is_store = st; acc_size = sz; ld_signed = sg; addr_lo = a;
        mem_rdata = rd; st_data = sd;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        // R10: reset clears outputs even with active inputs
        drive(1'b1, 2'b10, 1'b1, 2'd0, MEMW, STW);
        repeat (2) @(negedge clk);
        chk("R10", "reset ld", ld_data, 32'h0);
        chk("R10", "reset wd", wr_data, 32'h0);
        chk("R10", "reset be", {28'h0, wr_be}, 32'h0);
        chk("R10", "reset mis", {31'h0, misalign}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [74:0] v;
            v = VEC[i];
            drive(v[74], v[73:72], v[71], v[70:69], MEMW, STW);
            @(negedge clk);
            chk(vec_tag(i), "ld_data", ld_data, v[68:37]);
            chk(vec_tag(i), "wr_data", wr_data, v[36:5]);
            chk(vec_tag(i), "wr_be", {28'h0, wr_be}, {28'h0, v[4:1]});
            chk(vec_tag(i), "misalign", {31'h0, misalign}, {31'h0, v[0]});
        end

        // R4: halfword with bit 15 clear stays positive when signed
        drive(1'b0, 2'b01, 1'b1, 2'd0, 32'h0000_7F80, STW);
        @(negedge clk);
        chk("R4", "signed half bit15=0", ld_data, 32'h0000_7F80);

        // R3: byte 0x80 signed
        drive(1'b0, 2'b00, 1'b1, 2'd0, 32'h0000_7F80, STW);
        @(negedge clk);
        chk("R3", "signed byte 80", ld_data, 32'hFFFF_FF80);

        // R5: signed flag does not alter a word load
        drive(1'b0, 2'b10, 1'b0, 2'd0, 32'hF000_000F, STW);
        @(negedge clk);
        chk("R5", "word unsigned", ld_data, 32'hF000_000F);

        // R9: byte store at each offset gives matching one-hot enable
        for (int a = 0; a < 4; a++) begin
            drive(1'b1, 2'b00, 1'b0, 2'(a), MEMW, 32'h0000_005A);
            @(negedge clk);
            chk("R9", "byte be walk", {28'h0, wr_be}, 32'(4'b0001 << a));
            chk("R8", "byte wd walk", wr_data, 32'h5A5A_5A5A);
        end

        // R10: one-edge latency, output holds until the next edge
        drive(1'b0, 2'b00, 1'b0, 2'd1, MEMW, STW);
        @(negedge clk);
        drive(1'b0, 2'b00, 1'b0, 2'd2, MEMW, STW);
        #1;
        chk("R10", "held before edge", ld_data, 32'h0000_00F1);
        @(negedge clk);
        chk("R10", "updated after edge", ld_data, 32'h0000_0076);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule